// File: doc/BRIEF.md
# Chainable FIFO Slice with Token Hand-Off

This block is a synchronous FIFO slice that can run alone or as one link of a ring of identical slices. In a ring, every slice sees the same write enable, read enable and write data. Two tokens travel around the ring. The slice that holds the write token stores the incoming word. The slice that holds the read token returns the oldest word. When a slice uses its last storage location for a write or for a read, it hands the matching token to its neighbour with a one-cycle low pulse on `xout_n`. The neighbour can use the token in that same cycle, so moving from one slice to the next costs no idle cycle. Slices outside the ring drive zero on the data output, so the outputs of all slices can be ORed together.

Two straps are captured while reset is held: the level of `xin_n` and the level of `first_n`. If `xin_n` is low during reset, the slice runs alone as a plain FIFO. If it is high, which is the idle level of a neighbour's `xout_n`, the slice joins a ring. The slice whose `first_n` is low starts with both tokens. Each slice raises its full and empty flags only while it owns the matching token, so ORing the flags of all slices gives the flags of the whole buffer.

Top module: `xchain_fifo`

## Requirements
- R1: While reset is held and after it is released, no read is reported: `rd_oe`=0 and `rd_data`=0. `xout_n`=1 and `full`=0. `empty`=1 on a slice that starts with the read token, and `empty`=0 on any other ring slice.
- R2: If `xin_n`=0 while reset is held, the slice runs alone. It owns both tokens, stores up to DEPTH words and returns them in order, wraps its addresses, and keeps `xout_n` at 1 at all times.
- R3: If `xin_n`=1 while reset is held, the slice joins a ring. A slice with `first_n`=0 starts with both tokens. A slice with `first_n`=1 starts with neither token and ignores `wr_en` and `rd_en` until it receives a token.
- R4: In ring mode, an accepted write to storage address DEPTH-1 drives `xout_n` low during the next cycle. The write token leaves the slice. The receiving slice can accept a write during that same pulse cycle.
- R5: In ring mode, an accepted read from storage address DEPTH-1 hands the read token onward in the same way.
- R6: A ring slice treats the low pulses on `xin_n` after reset as write and read tokens in strict alternation, starting with a write token.
- R7: One cycle after an accepted read, `rd_oe`=1 and `rd_data` carries the word. In every other cycle, `rd_oe`=0 and `rd_data`=0, so outputs can be ORed.
- R8: A write is ignored while the owning slice holds DEPTH words, even if a read is accepted in the same cycle. A read is ignored while the owning slice holds no words.
- R9: `full` is 1 only while the slice owns the write token and holds DEPTH words. `empty` is 1 only while the slice owns the read token and holds no words. The OR of the slice flags gives the flags of the whole ring.
- R10: A write and a read accepted in the same cycle both take effect, and the stored word count does not change.
- R11: Across a ring of slices, words leave in the order they were written. This holds across every slice boundary and when the write and read positions wrap back to the first slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write request (bus shared by all slices) |
| rd_en | input | 1 | Read request (bus shared by all slices) |
| wr_data | input | WIDTH | Write data (bus shared by all slices) |
| xin_n | input | 1 | Token pulse from the previous slice; its level during reset selects the mode |
| first_n | input | 1 | Strap, active low: this slice starts with both tokens |
| rd_data | output | WIDTH | Read data; zero whenever `rd_oe` is low |
| rd_oe | output | 1 | Read data valid from this slice |
| full | output | 1 | This slice owns the write token and has no free location |
| empty | output | 1 | This slice owns the read token and has no stored word |
| xout_n | output | 1 | Token pulse to the next slice, active low |

## Verification
The hardest state to reach is the return of both tokens to the first slice after a full lap. The write token must arrive at a slice that is still completely full. The read token must then drain that slice before the write token can be used again. The stimulus gets there in three steps. It fills a three-slice ring of 512-word slices, 1536 words in all, and tries one extra write. It then drains every word in order. Finally it runs a long stretch of back-to-back combined reads and writes, so both tokens cross the first-to-second slice boundary while each one is busy on every cycle. A separate eight-word slice strapped to run alone is driven from a vector table that covers the empty and full edges.

// File: rtl/xchain_pkg.sv
package xchain_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_CHAIN  = 1'b1
  } mode_e;
endpackage

// File: rtl/xchain_rst_sync.sv
module xchain_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign arst_n = sync_q[1];
endmodule

// File: rtl/xchain_mem.sv
module xchain_mem #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/xchain_ctrl.sv
module xchain_ctrl #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          wr_own,
  input  logic          rd_own,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic          wr_wrap,
  output logic          rd_wrap,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          at_full,
  output logic          at_empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign at_full  = (cnt_q == CAP);
  assign at_empty = (cnt_q == '0);
  assign wr_fire  = wr_req & wr_own & ~at_full;
  assign rd_fire  = rd_req & rd_own & ~at_empty;
  assign wr_wrap  = wr_fire & (wp_q == LAST);
  assign rd_wrap  = rd_fire & (rp_q == LAST);
  assign wr_addr  = wp_q;
  assign rd_addr  = rp_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (wr_fire) wp_d = wr_wrap ? '0 : wp_q + AW'(1);
    if (rd_fire) rp_d = rd_wrap ? '0 : rp_q + AW'(1);
    case ({wr_fire, rd_fire})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // R8: the level never exceeds capacity, and a full slice stays full without a read
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q <= CAP);
  p_full_holds_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (at_full && !rd_fire) |=> at_full);
  // R10: a combined write and read leaves the level unchanged
  p_pair_level_r10: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_fire && rd_fire) |=> $stable(cnt_q));
endmodule

// File: rtl/xchain_token.sv
module xchain_token (
  input  logic clk,
  input  logic arst_n,
  input  logic chain_mode,
  input  logic first_load,
  input  logic xin_n,
  input  logic wr_wrap,
  input  logic rd_wrap,
  output logic wr_own,
  output logic rd_own,
  output logic xout_n
);
  logic wflip_q, wflip_d, rflip_q, rflip_d;
  logic next_rd_q, next_rd_d, xo_q, xo_d;
  logic wr_hold, rd_hold, pulse_in, wr_arrive, rd_arrive;

  assign wr_hold   = first_load ^ wflip_q;
  assign rd_hold   = first_load ^ rflip_q;
  assign pulse_in  = chain_mode & ~xin_n;
  assign wr_arrive = pulse_in & ~next_rd_q;
  assign rd_arrive = pulse_in & next_rd_q;
  assign wr_own    = ~chain_mode | wr_hold | wr_arrive;
  assign rd_own    = ~chain_mode | rd_hold | rd_arrive;
  assign xout_n    = xo_q;

  always_comb begin
    wflip_d   = ((wr_hold | wr_arrive) & ~wr_wrap) ^ first_load;
    rflip_d   = ((rd_hold | rd_arrive) & ~rd_wrap) ^ first_load;
    next_rd_d = next_rd_q ^ pulse_in;
    xo_d      = ~(chain_mode & (wr_wrap | rd_wrap));
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wflip_q   <= 1'b0;
      rflip_q   <= 1'b0;
      next_rd_q <= 1'b0;
      xo_q      <= 1'b1;
    end else begin
      wflip_q   <= wflip_d;
      rflip_q   <= rflip_d;
      next_rd_q <= next_rd_d;
      xo_q      <= xo_d;
    end
  end

  // R4 / R5: a token used at the last location leaves this slice
  p_wr_token_leaves_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (chain_mode && wr_wrap) |=> !wr_hold);
  p_rd_token_leaves_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (chain_mode && rd_wrap) |=> !rd_hold);
  // R6: one slice never hands off both tokens in the same cycle
  p_one_pass_r6: assert property (@(posedge clk) disable iff (!arst_n)
    !(wr_wrap && rd_wrap));
  // R2: a stand-alone slice never pulses its token output
  p_single_quiet_r2: assert property (@(posedge clk) disable iff (!arst_n)
    !chain_mode |-> xout_n);
endmodule

// File: rtl/xchain_fifo.sv
module xchain_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             xin_n,
  input  logic             first_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe,
  output logic             full,
  output logic             empty,
  output logic             xout_n
);
  import xchain_pkg::*;

  logic             arst_n;
  mode_e            mode_q;
  logic             first_q, chain;
  logic             wr_own, rd_own, wr_fire, rd_fire, wr_wrap, rd_wrap;
  logic             at_full, at_empty, oe_q;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [WIDTH-1:0] mem_q;

  xchain_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .arst_n(arst_n));

  // Straps are captured on every clock while reset is held
  always_ff @(posedge clk) begin
    if (!arst_n) begin
      mode_q  <= xin_n ? MODE_CHAIN : MODE_SINGLE;
      first_q <= ~first_n;
    end
  end

  assign chain = (mode_q == MODE_CHAIN);

  xchain_token u_tok (
    .clk(clk), .arst_n(arst_n), .chain_mode(chain), .first_load(first_q),
    .xin_n(xin_n), .wr_wrap(wr_wrap), .rd_wrap(rd_wrap),
    .wr_own(wr_own), .rd_own(rd_own), .xout_n(xout_n)
  );

  xchain_ctrl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .arst_n(arst_n), .wr_req(wr_en), .rd_req(rd_en),
    .wr_own(wr_own), .rd_own(rd_own), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .wr_wrap(wr_wrap), .rd_wrap(rd_wrap), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .at_full(at_full), .at_empty(at_empty)
  );

  xchain_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_fire), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_fire), .raddr(rd_addr), .rdata(mem_q)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) oe_q <= 1'b0;
    else         oe_q <= rd_fire;
  end

  assign rd_oe   = oe_q;
  assign rd_data = oe_q ? mem_q : '0;
  assign full    = wr_own & at_full;
  assign empty   = rd_own & at_empty;

  // R7: valid output only follows a read request
  p_oe_after_req_r7: assert property (@(posedge clk) disable iff (!arst_n)
    rd_oe |-> $past(rd_en));
  // R3: output driven only by a slice that owned the read token
  p_oe_owner_r3: assert property (@(posedge clk) disable iff (!arst_n)
    rd_oe |-> $past(rd_own));
  // R9: the two flags never coincide
  p_flags_apart_r9: assert property (@(posedge clk) disable iff (!arst_n)
    !(full && empty));
endmodule

// File: tb/xchain_fifo_test.sv
`timescale 1ns/1ps
module xchain_fifo_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic rst_n;
  // ring of three 512-word slices
  logic       wr_en, rd_en;
  logic [8:0] wr_data;
  logic [8:0] d_a, d_b, d_c;
  logic       oe_a, oe_b, oe_c, f_a, f_b, f_c, e_a, e_b, e_c, xo_a, xo_b, xo_c;
  // stand-alone 8-word slice
  logic       s_wr, s_rd;
  logic [8:0] s_din, s_dout;
  logic       s_oe, s_full, s_empty, s_xo;

  xchain_fifo #(.WIDTH(9), .DEPTH(512)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .xin_n(xo_c), .first_n(1'b0), .rd_data(d_a), .rd_oe(oe_a),
    .full(f_a), .empty(e_a), .xout_n(xo_a));
  xchain_fifo #(.WIDTH(9), .DEPTH(512)) uut_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .xin_n(xo_a), .first_n(1'b1), .rd_data(d_b), .rd_oe(oe_b),
    .full(f_b), .empty(e_b), .xout_n(xo_b));
  xchain_fifo #(.WIDTH(9), .DEPTH(512)) uut_c (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .xin_n(xo_b), .first_n(1'b1), .rd_data(d_c), .rd_oe(oe_c),
    .full(f_c), .empty(e_c), .xout_n(xo_c));
  xchain_fifo #(.WIDTH(9), .DEPTH(8)) uut_s (
    .clk(clk), .rst_n(rst_n), .wr_en(s_wr), .rd_en(s_rd), .wr_data(s_din),
    .xin_n(1'b0), .first_n(1'b1), .rd_data(s_dout), .rd_oe(s_oe),
    .full(s_full), .empty(s_empty), .xout_n(s_xo));

  wire [8:0] ring_d  = d_a | d_b | d_c;
  wire       ring_oe = oe_a | oe_b | oe_c;
  wire       ring_f  = f_a | f_b | f_c;
  wire       ring_e  = e_a | e_b | e_c;

  // {wr, rd, din[8:0], exp_oe, exp_dout[8:0], exp_full, exp_empty}
  localparam logic [22:0] TAB [24] = '{
    {1'b0,1'b1,9'h000, 1'b0,9'h000,1'b0,1'b1},
    {1'b1,1'b0,9'h101, 1'b0,9'h000,1'b0,1'b0},
    {1'b1,1'b0,9'h102, 1'b0,9'h000,1'b0,1'b0},
    {1'b0,1'b1,9'h000, 1'b1,9'h101,1'b0,1'b0},
    {1'b1,1'b1,9'h103, 1'b1,9'h102,1'b0,1'b0},
    {1'b0,1'b1,9'h000, 1'b1,9'h103,1'b0,1'b1},
    {1'b0,1'b1,9'h000, 1'b0,9'h000,1'b0,1'b1},
    {1'b1,1'b0,9'h110, 1'b0,9'h000,1'b0,1'b0},
    {1'b1,1'b0,9'h111, 1'b0,9'h000,1'b0,1'b0},
    {1'b1,1'b0,9'h112, 1'b0,9'h000,1'b0,1'b0},
    {1'b1,1'b0,9'h113, 1'b0,9'h000,1'b0,1'b0},
    {1'b1,1'b0,9'h114, 1'b0,9'h000,1'b0,1'b0},
    {1'b1,1'b0,9'h115, 1'b0,9'h000,1'b0,1'b0},
    {1'b1,1'b0,9'h116, 1'b0,9'h000,1'b0,1'b0},
    {1'b1,1'b0,9'h117, 1'b0,9'h000,1'b1,1'b0},
    {1'b1,1'b0,9'h1FF, 1'b0,9'h000,1'b1,1'b0},
    {1'b1,1'b1,9'h1EE, 1'b1,9'h110,1'b0,1'b0},
    {1'b0,1'b1,9'h000, 1'b1,9'h111,1'b0,1'b0},
    {1'b0,1'b1,9'h000, 1'b1,9'h112,1'b0,1'b0},
    {1'b0,1'b1,9'h000, 1'b1,9'h113,1'b0,1'b0},
    {1'b0,1'b1,9'h000, 1'b1,9'h114,1'b0,1'b0},
    {1'b0,1'b1,9'h000, 1'b1,9'h115,1'b0,1'b0},
    {1'b0,1'b1,9'h000, 1'b1,9'h116,1'b0,1'b0},
    {1'b0,1'b1,9'h000, 1'b1,9'h117,1'b0,1'b1}
  };

  function automatic logic [8:0] word(int i);
    return 9'((i * 5 + (i / 512) * 77) % 512);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ring_cyc(input logic w, input logic r, input logic [8:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic ring_read_chk(input int idx, input string req);
    chk(ring_oe && ring_d == word(idx), req, {ring_oe, ring_d}, {1'b1, word(idx)});
    chk($countones({oe_a, oe_b, oe_c}) == 1, "R7 single driver", {oe_a, oe_b, oe_c}, 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int wi, ri;
    rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    s_wr = 1'b0; s_rd = 1'b0; s_din = '0;
    repeat (6) @(posedge clk);
    #1;
    // R1 during reset
    chk(!ring_oe && ring_d == 0 && !s_oe && s_dout == 0, "R1 in reset", {ring_oe, s_oe}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1, R3: state after release
    chk(e_a && !e_b && !e_c, "R1 ring empty flags", {e_a, e_b, e_c}, 3'b100);
    chk(!ring_f && !ring_oe && ring_d == 0, "R1 ring full/oe", {ring_f, ring_oe}, 0);
    chk(xo_a && xo_b && xo_c && s_xo, "R1 xout idle", {xo_a, xo_b, xo_c, s_xo}, 4'hF);
    chk(s_empty && !s_full, "R1 single flags", {s_full, s_empty}, 2'b01);

    // R2, R7, R8, R10: stand-alone slice vector table
    for (int i = 0; i < 24; i++) begin
      logic [22:0] v;
      v = TAB[i];
      @(negedge clk);
      s_wr = v[22]; s_rd = v[21]; s_din = v[20:12];
      @(posedge clk);
      #1;
      chk(s_oe == v[11] && s_dout == v[10:2], $sformatf("R7 R8 R10 single row %0d data", i),
          {s_oe, s_dout}, {v[11], v[10:2]});
      chk(s_full == v[1] && s_empty == v[0], $sformatf("R2 R9 single row %0d flags", i),
          {s_full, s_empty}, v[1:0]);
      chk(s_xo, "R2 single xout idle", s_xo, 1);
    end
    @(negedge clk);
    s_wr = 1'b0; s_rd = 1'b0;

    // R3: read while ring is empty does nothing
    ring_cyc(1'b0, 1'b1, 9'h0);
    chk(!ring_oe && ring_d == 0, "R3 R8 read of empty ring", ring_oe, 0);

    // R4, R6, R11: fill all three slices
    for (int i = 0; i < 1536; i++) begin
      ring_cyc(1'b1, 1'b0, word(i));
      if (i == 511) chk(!xo_a && xo_b && xo_c, "R4 write token pulse", {xo_a, xo_b, xo_c}, 3'b011);
      if (i == 512) chk(xo_a, "R4 pulse one cycle", xo_a, 1);
      if (i == 512) chk(!ring_f, "R9 full hidden without token", ring_f, 0);
      if (i == 1535) chk(!xo_c, "R4 write token returns to first", xo_c, 0);
    end
    chk(f_a && !f_b && !f_c, "R9 R6 full at first slice", {f_a, f_b, f_c}, 3'b100);
    ring_cyc(1'b1, 1'b0, 9'h1AB);
    chk(ring_f, "R8 write at full ignored, still full", ring_f, 1);

    // R5, R7, R11: drain in order
    for (int i = 0; i < 1536; i++) begin
      ring_cyc(1'b0, 1'b1, 9'h0);
      ring_read_chk(i, $sformatf("R11 R5 read %0d", i));
      if (i == 511) chk(!xo_a, "R5 read token pulse", xo_a, 0);
    end
    chk(ring_e && e_a, "R9 ring empty after drain", {ring_e, e_a}, 2'b11);
    ring_cyc(1'b0, 1'b1, 9'h0);
    chk(!ring_oe && ring_d == 0, "R8 read of empty ignored", {ring_oe, ring_d}, 0);

    // R10, R11: wrap back to first slice with combined traffic
    wi = 1536; ri = 1536;
    for (int i = 0; i < 10; i++) begin
      ring_cyc(1'b1, 1'b0, word(wi));
      wi++;
    end
    for (int i = 0; i < 590; i++) begin
      ring_cyc(1'b1, 1'b1, word(wi));
      wi++;
      ring_read_chk(ri, $sformatf("R10 R11 combined read %0d", ri));
      ri++;
    end
    for (int i = 0; i < 10; i++) begin
      ring_cyc(1'b0, 1'b1, 9'h0);
      ring_read_chk(ri, $sformatf("R11 tail read %0d", ri));
      ri++;
    end
    chk(ring_e && !ring_f, "R9 empty after wrap", {ring_e, ring_f}, 2'b10);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule